// File: doc/BRIEF.md
# Receive Line Noise Filter

This block cleans up one asynchronous serial receive line before a bus-message receiver sees it. The raw line is first brought into the filter clock domain by a short chain of rising-edge flops. A sample register then takes its value on every rising edge. On each falling edge, a saturating up/down counter moves one step towards full scale if the latest sample is high, and one step towards zero if it is low.

A hysteresis latch drives the filtered output. It goes high only when the counter reaches full scale and goes low only when the counter reaches zero. A clean level change therefore reaches the output a fixed 15 to 16 filter-clock periods later, plus the synchronizer lag. Any pulse that is too short to carry the counter from one end to the other is never seen. The receiver downstream must allow for this delay during arbitration.

A debug view of the counter is brought out for observation.

Top module: `rx_glitch_filter`

## Requirements
- R1: The raw line passes through SYNC_STAGES rising-edge flops and is then captured by a sample register on the following rising edge, so the counter acts on the line value SYNC_STAGES+1 rising edges late.
- R2: While rst_n is low (asynchronous, active low), the synchronizer, the sample, the counter and rx_clean are all 0, starting at once and without any clock edge.
- R3: On each falling edge of clk_f, the counter adds 1 when the most recent sample is 1 and subtracts 1 when it is 0.
- R4: The counter saturates. It stays at 2**CNT_W-1 (15 by default) on a high sample and stays at 0 on a low sample.
- R5: rx_clean becomes 1 on the falling edge where the counter reaches full scale, and becomes 0 on the falling edge where it reaches 0. A high pulse lasting exactly 15 samples from the saturated-low state sets the output.
- R6: Between the end points rx_clean holds its value. For example, a single low sample after saturation at full scale takes the counter to 14 while rx_clean stays 1.
- R7: Take the filter saturated at one end and change the line just after a rising edge. The changed level first shows on rx_clean after SYNC_STAGES+16 falling edges, which is 15 to 16 periods plus the synchronizer lag.
- R8: A pulse of 14 periods or fewer applied to a saturated filter never changes rx_clean. The counter peaks at 14.
- R9: A noisy line that is high on average eventually drives rx_clean to 1 when starting from reset.
- R10: dbg_level always shows the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_f | input | 1 | Filter clock; rising edge samples, falling edge integrates |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_raw | input | 1 | Unsynchronized receive line |
| rx_clean | output | 1 | Filtered receive data |
| dbg_level | output | CNT_W | Current integrator count |

## Verification
The bench builds the filter with its default values, a two-flop synchronizer and a 4-bit counter. With these, full scale is 15, so the 15-versus-14 pulse boundary and the 18-falling-edge step latency are short enough to probe exactly in both directions. Random level runs of 1 to 24 periods cross both saturation points many times and are compared every cycle against a bench model of the counter and the latch. A biased noisy stream checks that a mostly-high line ends up setting the output.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Chooses the integrator move from the sample and the end-point flags.
    function automatic step_e pick_step(input logic smp, input logic at_top, input logic at_bot);
        if (smp) begin
            return at_top ? STEP_HOLD : STEP_UP;
        end
        return at_bot ? STEP_HOLD : STEP_DOWN;
    endfunction

endpackage

// File: rtl/rxf_sampler.sv
module rxf_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic smp_out
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   smp;
    } smp_state_t;

    smp_state_t st_d, st_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_comb begin
                st_d.sync = line_in;
                st_d.smp  = st_q.sync[0];
            end
        end else begin : g_chain
            always_comb begin
                st_d.sync = {st_q.sync[SYNC_STAGES-2:0], line_in};
                st_d.smp  = st_q.sync[SYNC_STAGES-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_out = st_q.smp;

endmodule

// File: rtl/rxf_integrator.sv
module rxf_integrator #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp,
    output logic [CNT_W-1:0] level,
    output logic             held
);
    import rxf_pkg::*;

    localparam logic [CNT_W-1:0] FULL  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] EMPTY = '0;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
        logic out;
    } int_state_t;

    int_state_t st_d, st_q;
    step_e      step;

    always_comb begin
        step = pick_step(smp, st_q.cnt == FULL, st_q.cnt == EMPTY);
        st_d = st_q;
        unique case (step)
            STEP_UP:   st_d.cnt = st_q.cnt + cnt_t'(1);
            STEP_DOWN: st_d.cnt = st_q.cnt - cnt_t'(1);
            default:   st_d.cnt = st_q.cnt;
        endcase
        if (st_d.cnt == FULL) begin
            st_d.out = 1'b1;
        end else if (st_d.cnt == EMPTY) begin
            st_d.out = 1'b0;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.cnt;
    assign held  = st_q.out;

    // R3
    inc_step_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (smp && st_q.cnt != FULL) |=> (st_q.cnt == cnt_t'($past(st_q.cnt) + cnt_t'(1))));

    // R3
    dec_step_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (!smp && st_q.cnt != EMPTY) |=> (st_q.cnt == cnt_t'($past(st_q.cnt) - cnt_t'(1))));

    // R4
    no_overflow_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (smp && st_q.cnt == FULL) |=> (st_q.cnt == FULL));

    // R4
    no_underflow_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (!smp && st_q.cnt == EMPTY) |=> (st_q.cnt == EMPTY));

    // R5
    full_sets_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL) |-> st_q.out);

    // R5
    empty_clears_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (st_q.cnt == EMPTY) |-> !st_q.out);

    // R6
    hold_between_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !$stable(st_q.out) |-> (st_q.cnt == FULL || st_q.cnt == EMPTY));

endmodule

// File: rtl/rx_glitch_filter.sv
module rx_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk_f,
    input  logic             rst_n,
    input  logic             rx_raw,
    output logic             rx_clean,
    output logic [CNT_W-1:0] dbg_level
);

    logic smp;

    rxf_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sampler (
        .clk    (clk_f),
        .rst_n  (rst_n),
        .line_in(rx_raw),
        .smp_out(smp)
    );

    rxf_integrator #(
        .CNT_W(CNT_W)
    ) i_integrator (
        .clk  (clk_f),
        .rst_n(rst_n),
        .smp  (smp),
        .level(dbg_level),
        .held (rx_clean)
    );

    // R2
    reset_quiet_chk: assert property (@(posedge clk_f)
        !rst_n |-> (!rx_clean && dbg_level == '0));

endmodule

// File: tb/test_rx_glitch_filter.sv
module test_rx_glitch_filter;

    localparam int SYNC = 2;
    localparam int CW   = 4;
    localparam int FULL = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b0;
    logic          rx_clean;
    logic [CW-1:0] dbg_level;

    int tests = 0;
    int fails = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rx_glitch_filter #(.SYNC_STAGES(SYNC), .CNT_W(CW)) i_rx_glitch_filter (
        .clk_f(clk), .rst_n(rst_n), .rx_raw(rx),
        .rx_clean(rx_clean), .dbg_level(dbg_level)
    );

    // Bench reference model, built from the requirements
    function automatic int f_next_cnt(input int c, input logic s);
        if (s) return (c == FULL) ? c : c + 1;
        return (c == 0) ? c : c - 1;
    endfunction

    function automatic logic f_next_out(input logic o, input int c);
        if (c == FULL) return 1'b1;
        if (c == 0) return 1'b0;
        return o;
    endfunction

    logic [SYNC-1:0] m_sync;
    logic            m_smp;
    int              m_cnt;
    logic            m_out;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sync <= '0;
            m_smp  <= 1'b0;
        end else begin
            m_sync <= {m_sync[SYNC-2:0], rx};
            m_smp  <= m_sync[SYNC-1];
        end
    end

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0;
            m_out <= 1'b0;
        end else begin
            m_cnt <= f_next_cnt(m_cnt, m_smp);
            m_out <= f_next_out(m_out, f_next_cnt(m_cnt, m_smp));
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, 3 ns after each falling edge
    always @(negedge clk) begin
        #3;
        if (chk_en && rst_n) begin
            check(int'(dbg_level) == m_cnt, "R3/R4/R10 level", int'(dbg_level), m_cnt);
            check(rx_clean == m_out, "R5/R6 output", int'(rx_clean), int'(m_out));
        end
    end

    task automatic hold_line(input logic v, input int n);
        @(posedge clk);
        #2 rx = v;
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic do_reset();
        #1 rst_n = 1'b0;
        #1;
        check(rx_clean == 1'b0, "R2 reset output", int'(rx_clean), 0);
        check(dbg_level == '0, "R2 reset level", int'(dbg_level), 0);
        rx = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    // Change the line just after a rising edge, count falling edges until the output follows
    task automatic step_latency(input logic v, input string req);
        int first = 0;
        @(posedge clk);
        #2 rx = v;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            #3;
            if (first == 0 && rx_clean == v) first = k;
        end
        check(first == SYNC + 16, req, first, SYNC + 16);
    endtask

    task automatic pulse_probe(input logic base, input int width, input int watch,
                               output int seen_flip, output int peak);
        seen_flip = 0;
        peak = base ? FULL : 0;
        hold_line(!base, width);
        @(posedge clk);
        #2 rx = base;
        for (int k = 0; k < watch; k++) begin
            @(negedge clk);
            #3;
            if (rx_clean != base) seen_flip = 1;
            if (base ? (int'(dbg_level) < peak) : (int'(dbg_level) > peak)) peak = int'(dbg_level);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int flip;
        int peak;
        int seen_high;
        void'($urandom(32'h5EED_0042));

        // R2: reset state
        do_reset();
        chk_en = 1'b1;
        hold_line(1'b0, 5);
        check(dbg_level == '0, "R2/R4 idle low level", int'(dbg_level), 0);

        // R7: rising step from saturated low, then falling step from saturated high (R1 lag included)
        step_latency(1'b1, "R7 R1 rise latency");
        hold_line(1'b1, 10);
        // R4: held at full scale
        check(int'(dbg_level) == FULL, "R4 saturate top", int'(dbg_level), FULL);
        step_latency(1'b0, "R7 R1 fall latency");
        hold_line(1'b0, 10);
        check(dbg_level == '0, "R4 saturate bottom", int'(dbg_level), 0);

        // R8: 14-period high pulse from low is rejected
        pulse_probe(1'b0, FULL - 1, 40, flip, peak);
        check(flip == 0, "R8 high glitch rejected", flip, 0);
        check(peak == FULL - 1, "R8 high glitch peak", peak, FULL - 1);

        // R5: 15-period pulse sets the output
        pulse_probe(1'b0, FULL, 40, flip, peak);
        check(flip == 1, "R5 15-sample pulse sets", flip, 1);
        check(peak == FULL, "R5 15-sample peak", peak, FULL);

        // R8: 14-period low pulse from high is rejected
        hold_line(1'b1, 30);
        pulse_probe(1'b1, FULL - 1, 40, flip, peak);
        check(flip == 0, "R8 low glitch rejected", flip, 0);
        check(peak == 1, "R8 low glitch floor", peak, 1);

        // R6: single low sample after full scale, output holds
        hold_line(1'b1, 30);
        pulse_probe(1'b1, 1, 20, flip, peak);
        check(flip == 0, "R6 hold at 14", flip, 0);
        check(peak == FULL - 1, "R6 dip to 14", peak, FULL - 1);

        // R2: asynchronous reset mid-run
        do_reset();

        // R9: noisy line, high on average
        seen_high = 0;
        for (int k = 0; k < 400; k++) begin
            @(posedge clk);
            #2 rx = (($urandom % 4) != 0);
            #3;
            if (rx_clean) seen_high = 1;
        end
        check(seen_high == 1, "R9 noisy high sets", seen_high, 1);

        // R3/R4/R5: random level runs compared against the model
        for (int r = 0; r < 250; r++) begin
            hold_line(logic'($urandom % 2), 1 + int'($urandom % 24));
        end

        repeat (4) @(posedge clk);
        chk_en = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule